// File: doc/BRIEF.md
# Command-Driven Random Word Generator

This block is a register-mapped controller for a random word generator. Software reaches it through a small 32-bit register bus with an address, a write strobe, write data, a read strobe and registered read data. A write to the command register either seeds the generator or asks for a block of random words. Software then watches a status register or an interrupt line, and pulls the block out one 32-bit word at a time from a data register.

The randomness comes from a 32-bit Galois LFSR that stands in for a physical source. Seeding is modelled as a fixed-latency load of a known constant. Generation steps the LFSR once per cycle and captures one word every sixteen cycles. Completion is reported in two ways: sticky interrupt flags that are cleared by writing one to them, and a seeded status bit that never clears. If a generate command arrives before the generator has been seeded, the block seeds itself first.

Top module: `rng_cmd_ctrl`

## Requirements
- R1: After reset, every readable register reads 0 and the interrupt output is 0.
- R2: Offset 0x08 holds a 2-bit length select in bits [1:0] and offset 0x10 holds a 2-bit interrupt enable in bits [1:0]. Both are read/write, and the other bits are ignored on write and read as 0. The command register at 0x00 reads 0. Offsets outside the map (for example 0x60) read 0.
- R3: Writing command value 2 to bits [1:0] at 0x00 starts a seed operation. While it runs, status bit 0 (busy) reads 1. Interrupt status bit 1 (at 0x14) sets at the 64th rising edge after the write edge, and status bit 9 (seeded) sets at the same edge.
- R4: Once seeded, status bit 9 stays at 1 through later commands and through flag clears.
- R5: On a seeded generator, writing command value 1 produces a block of N words, where N is 8 when the length select is 3 and 4 for any other value. Interrupt status bit 0 sets at the 16·N-th rising edge after the write edge.
- R6: The LFSR shifts right once per cycle during generation, XORing 0x80200003 when the bit shifted out is 1. A seed completion loads 0xACE12468. Word k of a block is the LFSR value after 16·(k+1) steps of that block, and the steps count up across blocks from the last seed. Successive reads of 0x20 return words 0 to N−1 in order and then wrap to word 0.
- R7: A generate command given before any seed runs a 64-cycle seed first and then the generation. Both interrupt status bits and the seeded bit end up set, and seed-done sets at the 64th edge.
- R8: Writing 1 to an interrupt status bit clears it. Writing 0 leaves it unchanged.
- R9: The interrupt output is a register holding the OR of (interrupt status AND enable). It follows a change of either one a single cycle later.
- R10: Commands written while busy are ignored, and the block length is fixed when a command starts. Command values 0 and 3 do nothing.
- R11: A new seed command reloads the LFSR, so the next block repeats the words of the first block after the earlier seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe, advances the data pointer at 0x20 |
| bus_rdata | output | 32 | Read data, registered one cycle after the strobe |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench sweeps every length select value and times the interrupt edge to the cycle. A design whose per-word or seed counter is off by one would raise the flag one cycle early or late. It reads one word beyond each block to catch a wrong wrap point, and it compares every word against an independent LFSR model, so a seed load that is missed or repeated shows up as wrong data. It also writes seed, generate and length changes during a busy generation: a design that accepted them would reseed, set seed-done, or change the block size, and the bench checks for all three. Partial flag clears and clears with the enable off catch a wrong write-one-to-clear mask or an interrupt that is not tied to its enable.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_STAT  = 'h04;
  localparam int OFS_MODE  = 'h08;
  localparam int OFS_IEN   = 'h10;
  localparam int OFS_ISTAT = 'h14;
  localparam int OFS_RAND  = 'h20;

  localparam logic [1:0] CMD_NOP  = 2'd0;
  localparam logic [1:0] CMD_GEN  = 2'd1;
  localparam logic [1:0] CMD_SEED = 2'd2;

  localparam logic [1:0] LEN_LONG = 2'd3;

  localparam int STAT_BUSY_BIT   = 0;
  localparam int STAT_SEEDED_BIT = 9;
  localparam int FLAG_RDY        = 0;
  localparam int FLAG_SEED       = 1;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_SEED = 2'd1,
    SQ_GEN  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] POLY = 32'h8020_0003,
  parameter logic [W-1:0] INIT = 32'hACE1_2468
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] next_val
);
  logic [W-1:0] state_q;

  always_comb begin
    next_val = {1'b0, state_q[W-1:1]};
    if (state_q[0]) next_val = next_val ^ POLY;
  end

  always_ff @(posedge clk) begin
    if (rst || load) state_q <= INIT;
    else if (step)   state_q <= next_val;
  end
endmodule

// File: rtl/rng_blkbuf.sv
module rng_blkbuf #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rng_seq.sv
module rng_seq
  import rng_pkg::*;
#(
  parameter int DW        = 32,
  parameter int SEED_CYC  = 64,
  parameter int WORD_CYC  = 16,
  parameter int MAX_WORDS = 8,
  localparam int SC_W     = $clog2(SEED_CYC),
  localparam int WC_W     = $clog2(WORD_CYC),
  localparam int WI_W     = $clog2(MAX_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd,
  input  logic            long_len,
  input  logic [DW-1:0]   lfsr_next,
  output logic            busy,
  output logic            seeded,
  output logic            seed_fin,
  output logic            gen_fin,
  output logic            lfsr_load,
  output logic            lfsr_step,
  output logic            buf_we,
  output logic [WI_W-1:0] buf_waddr,
  output logic [DW-1:0]   buf_wdata,
  output logic [WI_W-1:0] blk_last
);
  localparam logic [WI_W-1:0] LAST_LONG  = WI_W'(MAX_WORDS - 1);
  localparam logic [WI_W-1:0] LAST_SHORT = WI_W'(MAX_WORDS / 2 - 1);
  localparam logic [SC_W-1:0] SEED_LAST  = SC_W'(SEED_CYC - 1);
  localparam logic [WC_W-1:0] WORD_LAST  = WC_W'(WORD_CYC - 1);

  seq_state_t      state_q;
  logic [SC_W-1:0] seed_cnt_q;
  logic [WC_W-1:0] sub_q;
  logic [WI_W-1:0] widx_q;
  logic            gen_pend_q;
  logic            word_tick;

  assign busy      = (state_q != SQ_IDLE);
  assign seed_fin  = (state_q == SQ_SEED) && (seed_cnt_q == '0);
  assign word_tick = (state_q == SQ_GEN) && (sub_q == WORD_LAST);
  assign gen_fin   = word_tick && (widx_q == blk_last);
  assign lfsr_load = seed_fin;
  assign lfsr_step = (state_q == SQ_GEN);
  assign buf_we    = word_tick;
  assign buf_waddr = widx_q;
  assign buf_wdata = lfsr_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SQ_IDLE;
      seed_cnt_q <= '0;
      sub_q      <= '0;
      widx_q     <= '0;
      gen_pend_q <= 1'b0;
      seeded     <= 1'b0;
      blk_last   <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (cmd_valid && cmd == CMD_GEN) begin
            blk_last <= long_len ? LAST_LONG : LAST_SHORT;
            sub_q    <= '0;
            widx_q   <= '0;
            if (seeded) begin
              state_q <= SQ_GEN;
            end else begin
              state_q    <= SQ_SEED;
              seed_cnt_q <= SEED_LAST;
              gen_pend_q <= 1'b1;
            end
          end else if (cmd_valid && cmd == CMD_SEED) begin
            state_q    <= SQ_SEED;
            seed_cnt_q <= SEED_LAST;
            gen_pend_q <= 1'b0;
          end
        end
        SQ_SEED: begin
          if (seed_cnt_q == '0) begin
            seeded     <= 1'b1;
            gen_pend_q <= 1'b0;
            state_q    <= gen_pend_q ? SQ_GEN : SQ_IDLE;
          end else begin
            seed_cnt_q <= seed_cnt_q - 1'b1;
          end
        end
        SQ_GEN: begin
          if (word_tick) begin
            sub_q <= '0;
            if (widx_q == blk_last) state_q <= SQ_IDLE;
            else                    widx_q  <= widx_q + 1'b1;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  AST_GEN_AFTER_SEED: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_GEN) |-> seeded);                                   // R7
  AST_SEEDED_STICKY: assert property (@(posedge clk) disable iff (rst)
    seeded |=> seeded);                                                // R4
  AST_LEN_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(blk_last));                                       // R10
  AST_WIDX_IN_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_GEN) |-> (widx_q <= blk_last));                     // R5
endmodule

// File: rtl/rng_cmd_ctrl.sv
module rng_cmd_ctrl
  import rng_pkg::*;
#(
  parameter int          DW        = 32,
  parameter int          AW        = 8,
  parameter int          SEED_CYC  = 64,
  parameter int          WORD_CYC  = 16,
  parameter int          MAX_WORDS = 8,
  parameter logic [31:0] LFSR_POLY = 32'h8020_0003,
  parameter logic [31:0] LFSR_INIT = 32'hACE1_2468,
  localparam int         WI_W      = $clog2(MAX_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_re,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  logic [1:0]      len_sel_q;
  logic [1:0]      ien_q;
  logic [1:0]      istat_q;
  logic [WI_W-1:0] rd_ptr_q;

  logic            busy, seeded, seed_fin, gen_fin;
  logic            lfsr_load, lfsr_step, buf_we;
  logic [WI_W-1:0] buf_waddr, blk_last;
  logic [DW-1:0]   lfsr_next, buf_wdata, buf_rdata;
  logic [1:0]      flag_set, flag_clr;
  logic            wr_ctrl, wr_istat, rd_rand;
  logic            unused_wdata_hi;

  assign unused_wdata_hi = |bus_wdata[DW-1:2];
  assign wr_ctrl  = bus_we && (bus_addr == AW'(OFS_CTRL));
  assign wr_istat = bus_we && (bus_addr == AW'(OFS_ISTAT));
  assign rd_rand  = bus_re && (bus_addr == AW'(OFS_RAND));

  rng_lfsr #(.W(DW), .POLY(LFSR_POLY), .INIT(LFSR_INIT)) u_lfsr (
    .clk      (clk),
    .rst      (rst),
    .load     (lfsr_load),
    .step     (lfsr_step),
    .next_val (lfsr_next)
  );

  rng_seq #(.DW(DW), .SEED_CYC(SEED_CYC), .WORD_CYC(WORD_CYC),
            .MAX_WORDS(MAX_WORDS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (wr_ctrl),
    .cmd       (bus_wdata[1:0]),
    .long_len  (len_sel_q == LEN_LONG),
    .lfsr_next (lfsr_next),
    .busy      (busy),
    .seeded    (seeded),
    .seed_fin  (seed_fin),
    .gen_fin   (gen_fin),
    .lfsr_load (lfsr_load),
    .lfsr_step (lfsr_step),
    .buf_we    (buf_we),
    .buf_waddr (buf_waddr),
    .buf_wdata (buf_wdata),
    .blk_last  (blk_last)
  );

  rng_blkbuf #(.DW(DW), .DEPTH(MAX_WORDS)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_waddr),
    .wdata (buf_wdata),
    .raddr (rd_ptr_q),
    .rdata (buf_rdata)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[FLAG_RDY]  = gen_fin;
    flag_set[FLAG_SEED] = seed_fin;
    flag_clr            = wr_istat ? bus_wdata[1:0] : 2'b00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_sel_q <= '0;
      ien_q     <= '0;
      istat_q   <= '0;
      rd_ptr_q  <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_we && bus_addr == AW'(OFS_MODE)) len_sel_q <= bus_wdata[1:0];
      if (bus_we && bus_addr == AW'(OFS_IEN))  ien_q     <= bus_wdata[1:0];
      istat_q <= (istat_q & ~flag_clr) | flag_set;
      if (gen_fin)      rd_ptr_q <= '0;
      else if (rd_rand) rd_ptr_q <= (rd_ptr_q == blk_last) ? '0 : rd_ptr_q + 1'b1;
      irq <= |(istat_q & ien_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      bus_rdata <= '0;
      case (bus_addr)
        AW'(OFS_STAT): begin
          bus_rdata[STAT_BUSY_BIT]   <= busy;
          bus_rdata[STAT_SEEDED_BIT] <= seeded;
        end
        AW'(OFS_MODE):  bus_rdata[1:0] <= len_sel_q;
        AW'(OFS_IEN):   bus_rdata[1:0] <= ien_q;
        AW'(OFS_ISTAT): bus_rdata[1:0] <= istat_q;
        AW'(OFS_RAND):  bus_rdata      <= buf_rdata;
        default:        bus_rdata      <= '0;
      endcase
    end
  end

  AST_RDY_W1C: assert property (@(posedge clk) disable iff (rst)
    (wr_istat && bus_wdata[FLAG_RDY] && !gen_fin) |=> !istat_q[FLAG_RDY]);       // R8
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_istat && !gen_fin && !seed_fin) |=> $stable(istat_q));                   // R8
  AST_RDPTR_IN_BLOCK: assert property (@(posedge clk) disable iff (rst)
    rd_ptr_q <= blk_last);                                                        // R6
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(ien_q) != 2'b00));                                             // R9
endmodule

// File: tb/rng_cmd_ctrl_tb.sv
module rng_cmd_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] POLY = 32'h8020_0003;
  localparam logic [31:0] INIT = 32'hACE1_2468;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] m_lfsr;
  logic [31:0] exp_w [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  rng_cmd_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return s[0] ? ({1'b0, s[31:1]} ^ POLY) : {1'b0, s[31:1]};
  endfunction

  task automatic model_gen(input int n);
    for (int k = 0; k < n; k++) begin
      for (int j = 0; j < 16; j++) m_lfsr = lfsr_step(m_lfsr);
      exp_w[k] = m_lfsr;
    end
  endtask

  task automatic read_block(input string req, input int n);
    for (int k = 0; k <= n; k++) rd_chk(req, 8'h20, exp_w[k % n]);
  endtask

  // irq must rise exactly one cycle after the flag sets at edge 'lat'
  task automatic irq_timing(input string req, input int lat);
    repeat (lat) @(posedge clk);
    @(negedge clk);
    chk(req, {31'b0, irq}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk(req, {31'b0, irq}, 32'd1);
  endtask

  task automatic gen_and_check(input logic [1:0] m);
    int n;
    n = (m == 2'd3) ? 8 : 4;
    bus_wr(8'h08, {30'b0, m});
    bus_wr(8'h00, 32'd1);
    irq_timing("R5", 16 * n);
    model_gen(n);
    read_block("R6", n);
    bus_wr(8'h14, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst = 1'b0;
    // R1 reset state
    chk("R1", {31'b0, irq}, 32'd0);
    rd_chk("R1", 8'h04, 32'd0);
    rd_chk("R1", 8'h14, 32'd0);
    rd_chk("R1", 8'h08, 32'd0);
    rd_chk("R1", 8'h10, 32'd0);

    // R2 register map
    bus_wr(8'h08, 32'd3);
    rd_chk("R2", 8'h08, 32'd3);
    bus_wr(8'h08, 32'hFFFF_FFFD);
    rd_chk("R2", 8'h08, 32'd1);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    rd_chk("R2", 8'h10, 32'd3);
    rd_chk("R2", 8'h00, 32'd0);
    rd_chk("R2", 8'h60, 32'd0);
    bus_wr(8'h08, 32'd0);

    // R7 generate before seeding, seed-done timing via irq
    bus_wr(8'h10, 32'd2);
    bus_wr(8'h00, 32'd1);
    irq_timing("R7", 64);
    idle(100);
    rd_chk("R7", 8'h14, 32'd3);
    rd_chk("R7", 8'h04, 32'h200);
    m_lfsr = INIT;
    model_gen(4);
    read_block("R7", 4);

    // R8 write-one-to-clear
    bus_wr(8'h14, 32'd2);
    rd_chk("R8", 8'h14, 32'd1);
    bus_wr(8'h14, 32'd0);
    rd_chk("R8", 8'h14, 32'd1);
    bus_wr(8'h14, 32'd1);
    rd_chk("R8", 8'h14, 32'd0);
    rd_chk("R4", 8'h04, 32'h200);

    // R5 sweep of every length select value
    bus_wr(8'h10, 32'd1);
    for (int m = 0; m < 4; m++) gen_and_check(2'(m));

    // R3 explicit seed: latency, then busy bit during a second seed
    bus_wr(8'h10, 32'd2);
    bus_wr(8'h00, 32'd2);
    irq_timing("R3", 64);
    rd_chk("R3", 8'h04, 32'h200);
    bus_wr(8'h14, 32'd2);
    bus_wr(8'h00, 32'd2);
    rd_chk("R3", 8'h04, 32'h201);
    idle(80);
    rd_chk("R3", 8'h14, 32'd2);
    bus_wr(8'h14, 32'd2);
    m_lfsr = INIT;

    // R11 reseed repeats the sequence from the seed constant
    bus_wr(8'h10, 32'd1);
    gen_and_check(2'd3);

    // R10 commands and length change while busy are ignored
    bus_wr(8'h08, 32'd0);
    bus_wr(8'h00, 32'd1);
    bus_wr(8'h00, 32'd2);
    bus_wr(8'h00, 32'd1);
    bus_wr(8'h08, 32'd3);
    idle(200);
    rd_chk("R10", 8'h14, 32'd1);
    model_gen(4);
    read_block("R10", 4);
    bus_wr(8'h14, 32'd1);
    bus_wr(8'h08, 32'd0);
    bus_wr(8'h00, 32'd3);
    bus_wr(8'h00, 32'd0);
    idle(100);
    rd_chk("R10", 8'h14, 32'd0);
    rd_chk("R10", 8'h04, 32'h200);
    gen_and_check(2'd0);

    // R9 interrupt gated by enable, one cycle lag
    bus_wr(8'h10, 32'd0);
    bus_wr(8'h00, 32'd1);
    idle(100);
    chk("R9", {31'b0, irq}, 32'd0);
    model_gen(4);
    bus_wr(8'h10, 32'd1);
    chk("R9", {31'b0, irq}, 32'd0);
    @(negedge clk);
    chk("R9", {31'b0, irq}, 32'd1);
    bus_wr(8'h14, 32'd1);
    @(negedge clk);
    chk("R9", {31'b0, irq}, 32'd0);
    read_block("R6", 4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule